// File: doc/BRIEF.md
# Binary to BCD Converter (Restoring Subtract-Compare Chain)

This block turns an 8-bit unsigned binary value into three binary-coded decimal digits: hundreds, tens and units. It does not iterate. A fixed chain of six compare-and-subtract stages walks the value down through decimal-weighted constants. Each stage tests whether the running remainder reaches its constant. If it does, the stage raises one BCD output bit and hands on the reduced remainder. If not, it hands the remainder on untouched. The value left after the last stage is the units digit.

The converter is combinational. A parameter picks whether the three digits leave through a register, which is cleared by a synchronous active-low reset, or straight from the chain. It suits display paths and decimal formatting logic where an 8-bit count must be shown as decimal in a fixed number of cycles.

Top module: `bin_to_bcd_sc`

## Requirements
- R1: The hundreds digit, on `bcd_out[11:8]`, equals the input divided by 100, rounded down, for every input from 0 to 255.
- R2: The tens digit, on `bcd_out[7:4]`, equals the input divided by 10, rounded down, modulo 10.
- R3: The units digit, on `bcd_out[3:0]`, equals the input modulo 10.
- R4: `bcd_out[11:10]` is always zero, because the largest hundreds digit is 2.
- R5: No digit field ever holds a code above 9.
- R6: With `REG_OUT` = 1, `bcd_out` shows the conversion of the `bin_in` value sampled at the previous rising clock edge. A change on `bin_in` between edges does not alter `bcd_out`.
- R7: With `REG_OUT` = 1, a rising edge with `rst_n` low sets `bcd_out` to zero, whatever `bin_in` holds.
- R8: With `REG_OUT` = 0, `bcd_out` follows `bin_in` with no clock edge needed and gives the same digits as R1 to R3.
- R9: The chain tests the constants from largest to smallest: 200, 100, 80, 40, 20, 10. Each constant drives one output bit, in order: bit 9, bit 8, bit 7, bit 6, bit 5, bit 4. Any input of 200 or more therefore gives a hundreds digit of 2, never 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| bin_in | input | 8 | Unsigned binary value to convert |
| bcd_out | output | 12 | Hundreds in [11:8], tens in [7:4], units in [3:0] |

## Verification
The bench builds two copies of the block. One uses `REG_OUT` = 1 and is the registered instance `dut`. The other uses `REG_OUT` = 0 and is purely combinational. The registered copy brings within reach the one-cycle latency, the hold between edges and the reset clear. The combinational copy shows the chain settling with no clock edge. Both copies see an exhaustive sweep of all 256 inputs, the decade and threshold edges (9, 10, 99, 100, 199, 200, 255) and seeded random values. Every digit is compared against a division and modulo reference.

// File: rtl/bcdsc_pkg.sv
// Package: shared constants and helper functions for the subtract-compare
// binary to BCD converter.
// Assumes an 8-bit input, which gives six stages (two hundreds, four tens).
package bcdsc_pkg;

    localparam int unsigned DIGIT_W   = 4;
    localparam int unsigned N_DIGITS  = 3;
    localparam int unsigned BCD_W     = DIGIT_W * N_DIGITS;
    localparam int unsigned HUND_STG  = 2;   // hundreds bits that can be set
    localparam int unsigned TENS_STG  = 4;   // tens bits that can be set
    localparam int unsigned N_STAGES  = HUND_STG + TENS_STG;

    // Constant subtracted by stage idx: 200,100 then 80,40,20,10.
    function automatic int unsigned stage_const(input int unsigned idx);
        if (idx < HUND_STG)
            return 100 << (HUND_STG - 1 - idx);
        else
            return 10 << (N_STAGES - 1 - idx);
    endfunction

    // Output bit driven by stage idx: 9,8 (hundreds) then 7..4 (tens).
    function automatic int unsigned stage_bitpos(input int unsigned idx);
        return DIGIT_W + TENS_STG + HUND_STG - 1 - idx;
    endfunction

endpackage

// File: rtl/bcdsc_stage.sv
// Module: one restoring compare-and-subtract step.
// Compares rem_in with the constant K. When rem_in >= K it raises take
// and forwards rem_in - K; otherwise it forwards rem_in unchanged.
// Assumes K fits in W bits.
module bcdsc_stage #(
    parameter int unsigned W = 8,
    parameter int unsigned K = 10
) (
    input  logic [W-1:0] rem_in,
    output logic         take,
    output logic [W-1:0] rem_out
);

    localparam logic [W-1:0] KV = W'(K);

    logic [W-1:0] diff;
    logic         ge;

    // Subtractor: remainder minus the stage constant.
    always_comb begin
        diff = rem_in - KV;
    end

    // Comparator: remainder reaches the constant.
    always_comb begin
        ge = (rem_in >= KV);
    end

    // Multiplexer: pick the difference or the unchanged remainder.
    always_comb begin
        take    = ge;
        rem_out = ge ? diff : rem_in;
    end

endmodule

// File: rtl/bcdsc_chain.sv
// Module: the full chain of compare-subtract stages.
// Feeds the input through the stages from the largest constant to the
// smallest and packs the stage flags and the final remainder into BCD.
// Assumes IN_W = 8, so that the final remainder is below 10.
module bcdsc_chain
    import bcdsc_pkg::*;
#(
    parameter int unsigned IN_W = 8
) (
    input  logic [IN_W-1:0]  bin_in,
    output logic [BCD_W-1:0] bcd
);

    logic [IN_W-1:0]     rem [N_STAGES+1];
    logic [N_STAGES-1:0] take;

    // Entry point of the remainder chain.
    always_comb begin
        rem[0] = bin_in;
    end

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        bcdsc_stage #(
            .W (IN_W),
            .K (stage_const(g))
        ) u_stage (
            .rem_in  (rem[g]),
            .take    (take[g]),
            .rem_out (rem[g+1])
        );
    end

    // Pack the flags and the units remainder into the BCD word.
    always_comb begin
        bcd = '0;
        bcd[DIGIT_W-1:0] = rem[N_STAGES][DIGIT_W-1:0];
        for (int i = 0; i < N_STAGES; i++) begin
            bcd[stage_bitpos(i)] = take[i];
        end
    end

    // The final remainder must already be a units digit.
    always_comb begin
        if (!$isunknown(rem[N_STAGES])) begin
            AST_UNITS_BELOW_TEN: assert (rem[N_STAGES] < IN_W'(10)); // R3
        end
    end

endmodule

// File: rtl/bcdsc_outreg.sv
// Module: optional output register with a synchronous active-low reset.
// Assumes it is only instantiated when the registered variant is selected.
module bcdsc_outreg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the converted digits, or clear them during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/bin_to_bcd_sc.sv
// Module: top of the subtract-compare binary to BCD converter.
// REG_OUT = 1 puts the digits behind one register; REG_OUT = 0 leaves
// them combinational. Assumes an 8-bit unsigned input.
module bin_to_bcd_sc
    import bcdsc_pkg::*;
#(
    parameter int unsigned IN_W    = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  bin_in,
    output logic [BCD_W-1:0] bcd_out
);

    logic [BCD_W-1:0] bcd_c;

    bcdsc_chain #(
        .IN_W (IN_W)
    ) u_chain (
        .bin_in (bin_in),
        .bcd    (bcd_c)
    );

    if (REG_OUT) begin : g_reg
        logic primed;

        bcdsc_outreg #(
            .W (BCD_W)
        ) u_outreg (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (bcd_c),
            .q     (bcd_out)
        );

        // Marks that one edge out of reset has passed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                primed <= 1'b0;
            else
                primed <= 1'b1;
        end

        AST_HUND_FROM_PAST_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> ((bcd_out[11:8] != 4'd0) == ($past(bin_in) >= IN_W'(100)))); // R6
        AST_TWO_HUNDREDS: assert property (@(posedge clk) disable iff (!rst_n)
            primed && ($past(bin_in) >= IN_W'(200)) |-> (bcd_out[11:8] == 4'd2)); // R9
    end else begin : g_comb
        // Digits leave the chain directly.
        always_comb begin
            bcd_out = bcd_c;
        end

        AST_COMB_HUND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bin_in < IN_W'(100)) |-> (bcd_out[11:8] == 4'd0)); // R8
    end

    AST_HUND_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_out[11:10] == 2'b00); // R4
    AST_TENS_DIGIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_out[7:4] <= 4'd9); // R5
    AST_UNITS_DIGIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_out[3:0] <= 4'd9); // R5

endmodule

// File: tb/tb_bin_to_bcd_sc.sv
module tb_bin_to_bcd_sc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bin_in = 8'd0;
    logic [11:0] bcd_out;
    logic [11:0] bcd_comb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bin_to_bcd_sc #(.IN_W(8), .REG_OUT(1'b1)) dut (
        .clk (clk), .rst_n (rst_n), .bin_in (bin_in), .bcd_out (bcd_out)
    );

    bin_to_bcd_sc #(.IN_W(8), .REG_OUT(1'b0)) dut_comb (
        .clk (clk), .rst_n (rst_n), .bin_in (bin_in), .bcd_out (bcd_comb)
    );

    function automatic logic [11:0] ref_bcd(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive v after a falling edge and check both copies before the next edge.
    task automatic apply(input int v);
        @(negedge clk);
        bin_in = 8'(v);
        #1;
        check(bcd_comb, ref_bcd(v), "R8 comb digits");
        @(negedge clk);
        check({4'd0, bcd_out[11:8]}, {4'd0, ref_bcd(v)[11:8]}, "R1 hundreds");
        check({8'd0, bcd_out[7:4]}, {8'd0, ref_bcd(v)[7:4]}, "R2 tens");
        check({8'd0, bcd_out[3:0]}, {8'd0, ref_bcd(v)[3:0]}, "R3 units");
        check({10'd0, bcd_out[11:10]}, 12'd0, "R4 hundreds top bits");
        check({11'd0, (bcd_out[7:4] > 4'd9) || (bcd_out[3:0] > 4'd9)}, 12'd0, "R5 digit range");
    endtask

    initial begin
        int corners [8] = '{0, 9, 10, 99, 100, 199, 200, 255};
        void'($urandom(32'd4711));
        // R7: reset clears the register even with a large input present.
        bin_in = 8'd255;
        @(negedge clk);
        @(negedge clk);
        check(bcd_out, 12'd0, "R7 reset state");
        rst_n = 1'b1;

        foreach (corners[i]) apply(corners[i]);
        // R9: constant ordering at the 200 threshold.
        apply(200);
        check({8'd0, bcd_out[11:8]}, 12'd2, "R9 200 gives hundreds 2");

        for (int v = 0; v < 256; v++) apply(v);
        for (int n = 0; n < 300; n++) apply(int'($urandom_range(255, 0)));

        // R6: an input change between edges leaves the registered output alone.
        apply(37);
        @(negedge clk);
        bin_in = 8'd218;
        #2;
        check(bcd_out, ref_bcd(37), "R6 hold between edges");
        check(bcd_comb, ref_bcd(218), "R8 comb follows at once");
        @(negedge clk);
        check(bcd_out, ref_bcd(218), "R6 one cycle latency");

        // R7: reset in mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        check(bcd_out, 12'd0, "R7 mid-run reset");
        rst_n = 1'b1;
        apply(145);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule